// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a small single-port synchronous memory. Every input is captured in a register on the rising clock edge: the address, the write word, the write controls and the three chip enables. A write then finishes inside the block with no handshake. A write is either a global write or a lane write. A global write stores the whole word. A lane write uses a lane-write enable together with per-lane strobes and stores only the lanes whose strobes are active. Any selected cycle that writes no lane is a read.

Read data comes from a two-stage pipeline: the input register, then the array's registered read port. The word appears on the output two rising edges after the read is presented, together with a valid flag. When the block is not selected, or performs a write, the output stops driving one cycle later. Stopping to drive is modelled as the valid flag going low and the data bus going to zero. This stands in for releasing a shared data bus.

Top module: `lane_sram`

## Requirements
- R1: A read presented before rising edge N (address and controls set up before that edge) shows its word on `rdata_o`, with `rvalid_o` high, after edge N+1 and not before.
- R2: With `gw_n_i` low in a selected cycle, all four lanes of the addressed word are written, whatever `bwe_n_i` and `lane_n_i` hold.
- R3: With `gw_n_i` high, `bwe_n_i` low and some bits of `lane_n_i` low in a selected cycle, only the lanes whose strobe is low are written. Lane k is word bits [9k+8:9k] and `lane_n_i[k]` is its strobe. Every other lane keeps its old contents.
- R4: A selected cycle with `gw_n_i` high and either `bwe_n_i` high or `lane_n_i` all ones is a read and leaves the array unchanged.
- R5: The block is selected only when `ce_a_n_i` is low, `ce_b_i` is high and `ce_c_n_i` is low. In any other cycle nothing is written and nothing is read.
- R6: `rvalid_o` is high exactly one cycle after each selected read cycle has been registered. After a write or a deselected cycle it falls in the following cycle, so back-to-back reads stream one word per cycle.
- R7: A read of an address written in the immediately preceding cycle returns the newly written word.
- R8: After synchronous reset, `rvalid_o` is low and `rdata_o` is zero until a read completes.
- R9: Whenever `rvalid_o` is low, `rdata_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W (8) | Word address |
| wdata_i | input | LANES*LANE_W (36) | Write word |
| bwe_n_i | input | 1 | Lane-write enable, active low |
| lane_n_i | input | LANES (4) | Per-lane write strobes, active low |
| gw_n_i | input | 1 | Global write, active low |
| ce_a_n_i | input | 1 | Chip enable, active low |
| ce_b_i | input | 1 | Chip enable, active high |
| ce_c_n_i | input | 1 | Chip enable, active low |
| rdata_o | output | LANES*LANE_W (36) | Read word, zero when not driving |
| rvalid_o | output | 1 | Output driving with valid read data |

## Verification
Writes are applied as a global write with every strobe inactive and as a global write with mixed strobes. These two patterns show that the global write overrides the strobes. Single-lane and two-lane strobe patterns then show that only the selected lanes are touched. Strobes without the enable, and the enable without strobes, must both act as reads that return the old word, which separates the two conditions for a lane write. Each chip enable is dropped on its own during a write, and each case must block the write and release the output. A write followed directly by a read of the same address, and a stream of reads closed by a deselect, check pipeline forwarding and the one-cycle release.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_LANES = 2'd2,
    CYC_ALL   = 2'd3
  } cyc_kind_t;
endpackage

// File: rtl/lane_wr_decode.sv
module lane_wr_decode
  import lane_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             gw_n,
  output logic [LANES-1:0] lane_we,
  output logic             rd_en
);
  cyc_kind_t kind;

  always_comb begin
    if (!sel)                          kind = CYC_IDLE;
    else if (!gw_n)                    kind = CYC_ALL;
    else if (!bwe_n && !(&lane_n))     kind = CYC_LANES;
    else                               kind = CYC_READ;
  end

  always_comb begin
    unique case (kind)
      CYC_ALL:   lane_we = '1;
      CYC_LANES: lane_we = ~lane_n;
      default:   lane_we = '0;
    endcase
    rd_en = (kind == CYC_READ);
  end
endmodule

// File: rtl/lane_array.sv
module lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    rd_en,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_we[l]) mem[addr] <= wdata[l*LANE_W +: LANE_W];
      if (rd_en)      rd_q      <= mem[addr];
    end

    assign rdata[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/lane_rd_stage.sv
module lane_rd_stage #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] arr_q,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic drive_q;

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= rd_en;
  end

  assign rvalid_o = drive_q;
  assign rdata_o  = drive_q ? arr_q : '0;

  // R6
  rd_follows_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid_o);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid_o);
endmodule

// File: rtl/lane_sram.sv
module lane_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    bwe_n_i,
  input  logic [LANES-1:0]        lane_n_i,
  input  logic                    gw_n_i,
  input  logic                    ce_a_n_i,
  input  logic                    ce_b_i,
  input  logic                    ce_c_n_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  localparam int WORD_W = LANES * LANE_W;

  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              bwe_n_q, gw_n_q;
  logic [LANES-1:0]  lane_n_q;
  logic              ce_a_n_q, ce_b_q, ce_c_n_q;
  logic              sel_q;
  logic [LANES-1:0]  lane_we;
  logic              rd_en;
  logic [WORD_W-1:0] arr_q;

  // Input capture: controls reset to a deselected, no-write state.
  always_ff @(posedge clk) begin
    addr_q  <= addr_i;
    wdata_q <= wdata_i;
    if (rst) begin
      bwe_n_q  <= 1'b1;
      gw_n_q   <= 1'b1;
      lane_n_q <= '1;
      ce_a_n_q <= 1'b1;
      ce_b_q   <= 1'b0;
      ce_c_n_q <= 1'b1;
    end else begin
      bwe_n_q  <= bwe_n_i;
      gw_n_q   <= gw_n_i;
      lane_n_q <= lane_n_i;
      ce_a_n_q <= ce_a_n_i;
      ce_b_q   <= ce_b_i;
      ce_c_n_q <= ce_c_n_i;
    end
  end

  assign sel_q = !ce_a_n_q && ce_b_q && !ce_c_n_q;

  lane_wr_decode #(.LANES(LANES)) u_dec (
    .sel     (sel_q),
    .bwe_n   (bwe_n_q),
    .lane_n  (lane_n_q),
    .gw_n    (gw_n_q),
    .lane_we (lane_we),
    .rd_en   (rd_en)
  );

  lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk     (clk),
    .addr    (addr_q),
    .wdata   (wdata_q),
    .lane_we (lane_we),
    .rd_en   (rd_en),
    .rdata   (arr_q)
  );

  lane_rd_stage #(.WORD_W(WORD_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .arr_q    (arr_q),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  // R2
  global_all_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q && !gw_n_q) |-> (&lane_we && !rd_en));

  // R4
  plain_read_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q && gw_n_q && (bwe_n_q || &lane_n_q)) |-> (rd_en && lane_we == '0));

  // R5
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_q |-> (lane_we == '0 && !rd_en));
endmodule

// File: tb/lane_sram_test.sv
module lane_sram_test;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int WW = NL * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wdata = '0;
  logic          bwe_n = 1'b1;
  logic [NL-1:0] lane_n = '1;
  logic          gw_n = 1'b1;
  logic          ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
  logic [WW-1:0] rdata;
  logic          rvalid;

  int checks = 0;
  int fails  = 0;
  logic [WW-1:0] model [1<<AW];

  always #5 clk = ~clk;

  lane_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
    .clk(clk), .rst(rst), .addr_i(addr), .wdata_i(wdata), .bwe_n_i(bwe_n),
    .lane_n_i(lane_n), .gw_n_i(gw_n), .ce_a_n_i(ce_a_n), .ce_b_i(ce_b),
    .ce_c_n_i(ce_c_n), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act,
                     input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: set inputs, then wait to the falling edge after the next rising edge.
  task automatic cyc(input logic [AW-1:0] a, input logic [WW-1:0] d, input logic be,
                     input logic [NL-1:0] ln, input logic g, input logic an,
                     input logic b, input logic cn);
    addr = a; wdata = d; bwe_n = be; lane_n = ln; gw_n = g;
    ce_a_n = an; ce_b = b; ce_c_n = cn;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc('0, '0, 1'b1, '1, 1'b1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    cyc(a, '0, 1'b1, '1, 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  function automatic logic [WW-1:0] merge(input logic [WW-1:0] old,
      input logic [WW-1:0] d, input logic [NL-1:0] ln);
    logic [WW-1:0] r = old;
    for (int l = 0; l < NL; l++)
      if (!ln[l]) r[l*LW +: LW] = d[l*LW +: LW];
    return r;
  endfunction

  task automatic rd_check(input logic [AW-1:0] a, input string tag);
    rd(a);
    idle();
    chk(rvalid === 1'b1 && rdata === model[a], tag, rdata, model[a]);
  endtask

  task automatic t_reset();
    chk(rvalid === 1'b0, "R8 rvalid after reset", {35'd0, rvalid}, '0);
    chk(rdata === '0, "R8 rdata after reset", rdata, '0);
  endtask

  task automatic t_global();
    cyc(8'h05, 36'h1_2345_6789, 1'b1, 4'b1111, 1'b0, 1'b0, 1'b1, 1'b0);
    model[5] = 36'h1_2345_6789;
    idle();
    chk(rvalid === 1'b0, "R6 no valid after write", {35'd0, rvalid}, '0);
    rd(8'h05);
    chk(rvalid === 1'b0, "R1 not yet valid one edge after read", {35'd0, rvalid}, '0);
    idle();
    chk(rvalid === 1'b1 && rdata === model[5], "R1 R2 global write read back", rdata, model[5]);
    cyc(8'h05, 36'hA_BCDE_F012, 1'b0, 4'b1110, 1'b0, 1'b0, 1'b1, 1'b0);
    model[5] = 36'hA_BCDE_F012;
    rd_check(8'h05, "R2 global overrides strobes");
  endtask

  task automatic t_lanes();
    cyc(8'h05, 36'hF_FFFF_FFFF, 1'b0, 4'b1011, 1'b1, 1'b0, 1'b1, 1'b0);
    model[5] = merge(model[5], 36'hF_FFFF_FFFF, 4'b1011);
    rd_check(8'h05, "R3 single lane 2");
    cyc(8'h05, 36'h0_0000_0000, 1'b0, 4'b0101, 1'b1, 1'b0, 1'b1, 1'b0);
    model[5] = merge(model[5], 36'h0, 4'b0101);
    rd_check(8'h05, "R3 lanes 1 and 3");
  endtask

  task automatic t_noop();
    cyc(8'h05, 36'h5_5555_5555, 1'b1, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0);
    idle();
    chk(rvalid === 1'b1 && rdata === model[5], "R4 strobes without enable read", rdata, model[5]);
    cyc(8'h05, 36'h5_5555_5555, 1'b0, 4'b1111, 1'b1, 1'b0, 1'b1, 1'b0);
    idle();
    chk(rvalid === 1'b1 && rdata === model[5], "R4 enable without strobes read", rdata, model[5]);
  endtask

  task automatic t_deselect();
    for (int k = 0; k < 3; k++) begin
      cyc(8'h05, 36'h3_3333_3333, 1'b0, 4'b0000, 1'b0,
          (k == 0), (k != 1), (k == 2));
      idle();
      chk(rvalid === 1'b0 && rdata === '0, "R5 R9 deselected cycle output", rdata, '0);
      rd_check(8'h05, "R5 deselected write ignored");
    end
  endtask

  task automatic t_raw();
    cyc(8'h09, 36'h7_0F0F_0F0F, 1'b1, 4'b1111, 1'b0, 1'b0, 1'b1, 1'b0);
    model[9] = 36'h7_0F0F_0F0F;
    rd_check(8'h09, "R7 read right after write");
  endtask

  task automatic t_stream();
    cyc(8'h07, 36'h2_4680_ACE1, 1'b1, 4'b1111, 1'b0, 1'b0, 1'b1, 1'b0);
    model[7] = 36'h2_4680_ACE1;
    rd(8'h05);
    rd(8'h09);
    chk(rvalid === 1'b1 && rdata === model[5], "R6 stream word 1", rdata, model[5]);
    rd(8'h07);
    chk(rvalid === 1'b1 && rdata === model[9], "R6 stream word 2", rdata, model[9]);
    idle();
    chk(rvalid === 1'b1 && rdata === model[7], "R6 stream word 3", rdata, model[7]);
    idle();
    chk(rvalid === 1'b0 && rdata === '0, "R6 R9 release after deselect", rdata, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_global();
    t_lanes();
    t_noop();
    t_deselect();
    t_raw();
    t_stream();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule